// File: doc/BRIEF.md
# Sprite Attribute Page Copier

This block fills the 160-entry sprite attribute RAM from the system address space without CPU involvement. When the CPU writes a page number P to the block's one control register, the block copies 160 consecutive bytes starting at system address P·256 into attribute RAM offsets 0 to 159. The copy is paced by a clock-unit strobe (`tick`). After a trigger the engine waits a fixed number of strobes, then moves one byte per fixed group of strobes. In a byte-move cycle the engine issues a read on its master port and writes the returned byte into attribute RAM in that same cycle.

A source address at or above 0xE000 is mirrored down by clearing address bit 13 before it is issued. A write to the register while a copy is still in progress abandons that copy and starts again from the new page at offset 0. While a copy is in progress, the block tells the CPU-side arbiter to stall any CPU access that falls in the same bus class as the engine's current source. Bus classes are video RAM, work RAM and external. The register reads back the last value written to it. Its reset value depends on a colour-mode input.

Top module: `sprite_page_copier`

## Requirements
- R1: During reset, `reg_rdata` becomes 0x00 when `color_mode` is 1 and 0xFF when `color_mode` is 0.
- R2: After a cycle with `reg_wr` high, `reg_rdata` equals the written byte. All 256 values are accepted, and every write starts a copy.
- R3: A copy triggered with value V writes exactly 160 bytes, to `attr_addr` 0, 1, …, 159 in that order. The byte for offset i comes from source address V·256 + i.
- R4: The first byte moves in the 8th strobe cycle after the trigger cycle. Each later byte moves 4 strobe cycles after the previous one. Cycles with `tick` low advance nothing, and no byte moves in them.
- R5: A source address of 0xE000 or more is issued on `src_addr` with bit 13 cleared. A lower address is issued unchanged.
- R6: In a byte-move cycle `src_rd_en` and `attr_we` are both high. `attr_wdata` equals the `src_rd_data` returned for the issued `src_addr`.
- R7: A register write while bytes remain restarts the copy. The copy then runs from the new page at offset 0, with a full 160 bytes and a fresh 8-strobe start-up delay.
- R8: `cpu_block` is high only when all of these hold: bytes remain, `cpu_addr` is below 0xFE00, and `cpu_addr` has the same bus class as the current (unmirrored) source address.
- R9: In the start-up delay of a copy started from idle, `cpu_block` stays low. In the delay of a restarted copy it follows R8.
- R10: The cycle after the last byte moves, `cpu_block` is low and no further byte moves until the next write.
- R11: The bus classes are video RAM (0x8000–0x9FFF), work RAM (0xC000–0xFDFF) and external (all other addresses). The same mapping is used for `cpu_addr` and for the source address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| color_mode | input | 1 | Selects the register reset value |
| tick | input | 1 | Clock-unit strobe that paces the copy |
| reg_wr | input | 1 | CPU write to the control register |
| reg_wdata | input | 8 | Page number written by the CPU |
| reg_rdata | output | 8 | Control register read value |
| cpu_addr | input | 16 | Address of the CPU's current access |
| cpu_block | output | 1 | CPU access collides with the engine's bus |
| src_rd_en | output | 1 | Master read strobe |
| src_addr | output | 16 | Master read address, after mirroring |
| src_rd_data | input | 8 | Read data returned in the same cycle |
| attr_we | output | 1 | Attribute RAM write enable |
| attr_addr | output | 8 | Attribute RAM offset |
| attr_wdata | output | 8 | Attribute RAM write data |

## Verification
Full copies run from pages 0x00, 0x7F, 0xDF, 0xE0 and 0xFF. The source model returns a byte that depends on the address, so wrong ordering, a missing byte or a wrong mirror shows up in the copied data. Page 0xDF is the last page that passes through unchanged. Pages 0xE0 and 0xFF must read the work RAM pages below them. The pacing test compares a steady strobe with a strobe on every third cycle; this separates counting clocks from counting strobes. The stall output is tested in each bus class, at the 0xFE00 limit, in a start-up delay from idle and in a delay after a restart.

// File: rtl/sce_pkg.sv
package sce_pkg;
   typedef enum logic [1:0] {
      CLS_EXT  = 2'd0,
      CLS_VRAM = 2'd1,
      CLS_WRAM = 2'd2
   } bus_cls_e;
endpackage

// File: rtl/sce_bus_class.sv
module sce_bus_class #(
   parameter int unsigned       ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] VRAM_LO = 16'h8000,
   parameter logic [ADDR_W-1:0] VRAM_HI = 16'h9FFF,
   parameter logic [ADDR_W-1:0] WRAM_LO = 16'hC000,
   parameter logic [ADDR_W-1:0] WRAM_HI = 16'hFDFF
) (
   input  logic [ADDR_W-1:0] addr,
   output sce_pkg::bus_cls_e cls
);
   if (VRAM_LO > VRAM_HI || WRAM_LO > WRAM_HI) begin : g_bad_range
      $error("sce_bus_class: empty address window");
   end

   always_comb begin
      if (addr >= VRAM_LO && addr <= VRAM_HI)
         cls = sce_pkg::CLS_VRAM;
      else if (addr >= WRAM_LO && addr <= WRAM_HI)
         cls = sce_pkg::CLS_WRAM;
      else
         cls = sce_pkg::CLS_EXT;
   end
endmodule

// File: rtl/sce_src_fold.sv
module sce_src_fold #(
   parameter int unsigned       ADDR_W    = 16,
   parameter bit                FOLD_EN   = 1'b1,
   parameter logic [ADDR_W-1:0] FOLD_BASE = 16'hE000,
   parameter int unsigned       FOLD_BIT  = 13
) (
   input  logic [ADDR_W-1:0] in_addr,
   output logic [ADDR_W-1:0] out_addr
);
   if (FOLD_BIT >= ADDR_W) begin : g_bad_bit
      $error("sce_src_fold: FOLD_BIT outside address");
   end

   if (FOLD_EN) begin : g_fold
      always_comb begin
         out_addr = in_addr;
         if (in_addr >= FOLD_BASE)
            out_addr[FOLD_BIT] = 1'b0;
      end
   end else begin : g_pass
      assign out_addr = in_addr;
   end
endmodule

// File: rtl/sce_sequencer.sv
module sce_sequencer #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned PAGE_W      = 8,
   parameter int unsigned XFER_LEN    = 160,
   parameter int unsigned START_DELAY = 7,
   parameter int unsigned BYTE_PERIOD = 4,
   parameter int unsigned ATTR_AW     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PAGE_W-1:0]  page,
   input  logic               tick,
   output logic               busy,
   output logic               in_delay,
   output logic               restarting,
   output logic               move,
   output logic [ADDR_W-1:0]  src_ptr,
   output logic [ATTR_AW-1:0] dst_ptr
);
   localparam int unsigned SHIFT  = ADDR_W - PAGE_W;
   localparam int unsigned CNT_W  = $clog2(XFER_LEN + 1);
   localparam int unsigned WMAX   = (START_DELAY > BYTE_PERIOD) ? START_DELAY : BYTE_PERIOD;
   localparam int unsigned WAIT_W = $clog2(WMAX + 1);
   localparam logic [CNT_W-1:0]  LEN_C    = CNT_W'(XFER_LEN);
   localparam logic [WAIT_W-1:0] DLY_INIT = WAIT_W'(START_DELAY);
   localparam logic [WAIT_W-1:0] RELOAD   = WAIT_W'(BYTE_PERIOD - 1);

   logic [CNT_W-1:0]  left_q;
   logic [WAIT_W-1:0] wait_q;

   assign busy = (left_q != '0);
   assign move = busy && tick && (wait_q == '0) && !start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q     <= '0;
         wait_q     <= '0;
         src_ptr    <= '0;
         dst_ptr    <= '0;
         in_delay   <= 1'b0;
         restarting <= 1'b0;
      end else if (start) begin
         restarting <= busy;
         left_q     <= LEN_C;
         wait_q     <= DLY_INIT;
         src_ptr    <= {page, {SHIFT{1'b0}}};
         dst_ptr    <= '0;
         in_delay   <= 1'b1;
      end else if (busy && tick) begin
         if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
         end else begin
            left_q   <= left_q - 1'b1;
            src_ptr  <= src_ptr + 1'b1;
            dst_ptr  <= dst_ptr + 1'b1;
            wait_q   <= RELOAD;
            in_delay <= 1'b0;
            if (left_q == CNT_W'(1))
               restarting <= 1'b0;
         end
      end
   end

   // R4
   move_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      move |=> !move);

   // R7
   restart_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (dst_ptr == '0) && busy && in_delay);
endmodule

// File: rtl/sprite_page_copier.sv
module sprite_page_copier #(
   parameter int unsigned       ADDR_W      = 16,
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       XFER_LEN    = 160,
   parameter int unsigned       START_DELAY = 7,
   parameter int unsigned       BYTE_PERIOD = 4,
   parameter bit                FOLD_EN     = 1'b1,
   parameter logic [ADDR_W-1:0] FOLD_BASE   = 16'hE000,
   parameter int unsigned       FOLD_BIT    = 13,
   parameter logic [ADDR_W-1:0] HIGH_LIMIT  = 16'hFE00,
   parameter logic [DATA_W-1:0] RST_COLOR   = 8'h00,
   parameter logic [DATA_W-1:0] RST_MONO    = 8'hFF,
   parameter int unsigned       ATTR_AW     = $clog2(XFER_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               color_mode,
   input  logic               tick,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [ADDR_W-1:0]  cpu_addr,
   output logic               cpu_block,
   output logic               src_rd_en,
   output logic [ADDR_W-1:0]  src_addr,
   input  logic [DATA_W-1:0]  src_rd_data,
   output logic               attr_we,
   output logic [ATTR_AW-1:0] attr_addr,
   output logic [DATA_W-1:0]  attr_wdata
);
   localparam logic [ATTR_AW-1:0] LAST_OFS = ATTR_AW'(XFER_LEN - 1);

   if (ADDR_W <= DATA_W) begin : g_bad_width
      $error("sprite_page_copier: address must be wider than a page number");
   end
   if (BYTE_PERIOD < 2 || START_DELAY < 1) begin : g_bad_timing
      $error("sprite_page_copier: pacing too short");
   end
   if (XFER_LEN < 2 || XFER_LEN > (1 << ATTR_AW)) begin : g_bad_len
      $error("sprite_page_copier: transfer length does not fit offset");
   end

   logic [DATA_W-1:0] page_q;
   logic              busy, in_delay, restarting, move;
   logic [ADDR_W-1:0] src_ptr;
   sce_pkg::bus_cls_e cls_cpu, cls_src;

   always_ff @(posedge clk) begin
      if (!rst_n)
         page_q <= color_mode ? RST_COLOR : RST_MONO;
      else if (reg_wr)
         page_q <= reg_wdata;
   end
   assign reg_rdata = page_q;

   sce_sequencer #(
      .ADDR_W(ADDR_W), .PAGE_W(DATA_W), .XFER_LEN(XFER_LEN),
      .START_DELAY(START_DELAY), .BYTE_PERIOD(BYTE_PERIOD), .ATTR_AW(ATTR_AW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(reg_wr), .page(reg_wdata), .tick(tick),
      .busy(busy), .in_delay(in_delay), .restarting(restarting), .move(move),
      .src_ptr(src_ptr), .dst_ptr(attr_addr)
   );

   sce_src_fold #(
      .ADDR_W(ADDR_W), .FOLD_EN(FOLD_EN), .FOLD_BASE(FOLD_BASE), .FOLD_BIT(FOLD_BIT)
   ) u_fold (
      .in_addr(src_ptr), .out_addr(src_addr)
   );

   sce_bus_class #(.ADDR_W(ADDR_W)) u_cls_cpu (.addr(cpu_addr), .cls(cls_cpu));
   sce_bus_class #(.ADDR_W(ADDR_W)) u_cls_src (.addr(src_ptr),  .cls(cls_src));

   assign src_rd_en  = move;
   assign attr_we    = move;
   assign attr_wdata = src_rd_data;

   assign cpu_block = busy && (!in_delay || restarting) &&
                      (cpu_addr < HIGH_LIMIT) && (cls_cpu == cls_src);

   // R2
   readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> reg_rdata == $past(reg_wdata));

   // R5
   fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_rd_en && FOLD_EN) |-> src_addr < FOLD_BASE);

   // R8
   high_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_block |-> cpu_addr < HIGH_LIMIT);

   // R10
   done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (attr_we && attr_addr == LAST_OFS) |=> !cpu_block && !attr_we);
endmodule

// File: tb/sprite_page_copier_bench.sv
module sprite_page_copier_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        color_mode = 1'b1;
   logic        tick = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic [15:0] cpu_addr = 16'h0000;
   logic        cpu_block;
   logic        src_rd_en;
   logic [15:0] src_addr;
   logic [7:0]  src_rd_data;
   logic        attr_we;
   logic [7:0]  attr_addr;
   logic [7:0]  attr_wdata;

   int checks = 0;
   int errors = 0;
   int we_cnt = 0;
   int order_err = 0;
   int pair_err = 0;
   logic [7:0]  exp_next = 8'h00;
   logic [7:0]  mem  [160];
   logic [15:0] alog [160];

   always #5 clk = ~clk;

   sprite_page_copier u_sprite_page_copier (
      .clk(clk), .rst_n(rst_n), .color_mode(color_mode), .tick(tick),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_addr(cpu_addr), .cpu_block(cpu_block),
      .src_rd_en(src_rd_en), .src_addr(src_addr), .src_rd_data(src_rd_data),
      .attr_we(attr_we), .attr_addr(attr_addr), .attr_wdata(attr_wdata)
   );

   function automatic logic [7:0] model(logic [15:0] a);
      logic [7:0] h;
      h = a[15:8];
      return (h * 8'd3 + a[7:0]) ^ 8'h5A;
   endfunction

   function automatic logic [15:0] exp_addr(logic [7:0] v, int i);
      logic [15:0] s;
      s = {v, 8'h00} + 16'(i);
      if (s >= 16'hE000) s[13] = 1'b0;
      return s;
   endfunction

   assign src_rd_data = model(src_addr);

   always begin
      @(negedge clk);
      #3;
      if (rst_n && attr_we) begin
         if (attr_addr < 8'd160) begin
            mem[attr_addr]  = attr_wdata;
            alog[attr_addr] = src_addr;
         end
         if (attr_addr !== exp_next) order_err++;
         if (!src_rd_en || attr_wdata !== model(src_addr)) pair_err++;
         exp_next = attr_addr + 8'd1;
         we_cnt++;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic cm);
      @(negedge clk);
      rst_n = 1'b0; color_mode = cm; tick = 1'b0; reg_wr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #3;
   endtask

   task automatic trig(input logic [7:0] v);
      @(negedge clk);
      tick = 1'b0; reg_wr = 1'b1; reg_wdata = v;
      we_cnt = 0; exp_next = 8'h00; order_err = 0; pair_err = 0;
      @(negedge clk);
      reg_wr = 1'b0;
      #3;
      chk(reg_rdata == v, "R2 readback", int'(reg_rdata), int'(v));
   endtask

   task automatic finish_xfer();
      int g = 0;
      while (we_cnt < 160 && g < 3000) begin
         @(negedge clk); tick = 1'b1; #4; g++;
      end
      @(negedge clk);
      #3;
      chk(cpu_block == 1'b0 && attr_we == 1'b0, "R10 idle after last byte",
          int'({cpu_block, attr_we}), 0);
      repeat (20) @(negedge clk);
      tick = 1'b0;
      chk(we_cnt == 160, "R3/R10 byte count", we_cnt, 160);
   endtask

   task automatic verify_page(input logic [7:0] v);
      int bad_d = 0;
      int bad_a = 0;
      for (int i = 0; i < 160; i++) begin
         if (mem[i] !== model(exp_addr(v, i))) bad_d++;
         if (alog[i] !== exp_addr(v, i)) bad_a++;
      end
      chk(bad_d == 0 && order_err == 0, "R3 data/order", bad_d + order_err, 0);
      chk(bad_a == 0, "R5 issued source addresses", bad_a, 0);
      chk(pair_err == 0, "R6 read/write pairing", pair_err, 0);
   endtask

   task automatic t_reset();
      do_reset(1'b1);
      chk(reg_rdata == 8'h00, "R1 colour reset", int'(reg_rdata), 8'h00);
      chk(cpu_block == 1'b0 && attr_we == 1'b0, "R1 idle after reset", int'({cpu_block, attr_we}), 0);
      do_reset(1'b0);
      chk(reg_rdata == 8'hFF, "R1 mono reset", int'(reg_rdata), 8'hFF);
   endtask

   task automatic t_page(input logic [7:0] v);
      trig(v);
      finish_xfer();
      verify_page(v);
   endtask

   task automatic t_pacing();
      int first = 0;
      int second = 0;
      trig(8'h40);
      for (int k = 1; k <= 14; k++) begin
         @(negedge clk); tick = 1'b1; #3;
         if (attr_we && first == 0) first = k;
         else if (attr_we && second == 0) second = k;
      end
      chk(first == 8, "R4 first byte strobe", first, 8);
      chk(second == 12, "R4 byte spacing", second, 12);
      finish_xfer();
   endtask

   task automatic t_sparse();
      int k = 0;
      int n = 0;
      int first = 0;
      int idle_we = 0;
      trig(8'h55);
      while (first == 0 && k < 100) begin
         @(negedge clk);
         tick = (k % 3 == 0);
         #3;
         if (tick) n++;
         if (!tick && attr_we) idle_we++;
         if (tick && attr_we) first = n;
         k++;
      end
      chk(first == 8, "R4 first byte with sparse strobe", first, 8);
      chk(idle_we == 0, "R4 no move without strobe", idle_we, 0);
      finish_xfer();
      verify_page(8'h55);
   endtask

   task automatic probe(input logic [15:0] a, input logic e, input string tag);
      @(negedge clk);
      cpu_addr = a;
      #3;
      chk(cpu_block == e, tag, int'(cpu_block), int'(e));
   endtask

   task automatic t_conflict();
      int dly_block = 0;
      cpu_addr = 16'h4123;
      trig(8'h40);
      for (int k = 1; k <= 7; k++) begin
         @(negedge clk); tick = 1'b1; #3;
         if (cpu_block) dly_block++;
      end
      chk(dly_block == 0, "R9 no stall in delay from idle", dly_block, 0);
      repeat (3) begin @(negedge clk); tick = 1'b1; end
      tick = 1'b0;
      probe(16'h4123, 1'b1, "R8 same external class");
      probe(16'h0100, 1'b1, "R11 external low range");
      probe(16'h8100, 1'b0, "R11 video class differs");
      probe(16'hC100, 1'b0, "R11 work class differs");
      probe(16'hFE80, 1'b0, "R8 above limit");
      finish_xfer();
      trig(8'hC0);
      repeat (10) begin @(negedge clk); tick = 1'b1; end
      tick = 1'b0;
      probe(16'hE010, 1'b1, "R11 mirror area is work class");
      probe(16'hFDFF, 1'b1, "R8 just below limit");
      probe(16'hFE00, 1'b0, "R8 at limit");
      probe(16'h9000, 1'b0, "R11 video vs work");
      finish_xfer();
      trig(8'h80);
      repeat (10) begin @(negedge clk); tick = 1'b1; end
      tick = 1'b0;
      probe(16'h9FFF, 1'b1, "R11 video upper edge");
      probe(16'hA000, 1'b0, "R11 above video is external");
      finish_xfer();
   endtask

   task automatic t_restart();
      int g = 0;
      int rs_block = 0;
      int first = 0;
      cpu_addr = 16'h3400;
      trig(8'h12);
      while (we_cnt < 10 && g < 200) begin
         @(negedge clk); tick = 1'b1; #4; g++;
      end
      trig(8'h34);
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk); tick = 1'b1; #3;
         if (k <= 7 && !cpu_block) rs_block++;
         if (attr_we && first == 0) first = k;
      end
      chk(rs_block == 0, "R9 stall held in restart delay", rs_block, 0);
      chk(first == 8, "R7 fresh delay after restart", first, 8);
      finish_xfer();
      verify_page(8'h34);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_page(8'h00);
      t_page(8'h7F);
      t_page(8'hDF);
      t_page(8'hE0);
      t_page(8'hFF);
      t_pacing();
      t_sparse();
      t_conflict();
      t_restart();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule